// File: doc/BRIEF.md
# Transmit Character Front-End Selector

This block is the registered input stage in front of an 8B/10B encoder. On every rising edge of the reference clock it samples one host character together with its control bits. These are an active-low transmit enable, a request to send a code violation, a data/special select, a parity enable and a parity bit. It then decides what the encoder receives in the next cycle. The choices are the host character, the K28.5 fill character, or a violation symbol. A violation symbol has its own strobe, so the encoder can emit a deliberate code violation.

When the host leaves the enable deasserted, the line keeps running on fill characters, so the host never needs to stall the serial stream. When parity checking is on, a character whose parity is wrong is not sent. A violation symbol goes out in its place, so the far end can see the fault, and a one-cycle error pulse is raised locally. A bypass mode skips the encoder path completely and forwards 10-bit words that were encoded upstream.

Top module: `txfe_front_sel`

## Requirements
- R1: Every output is registered. The decision for the inputs sampled at one rising clock edge appears on the outputs right after that edge and holds until the next edge.
- R2: In encoded mode (`bypass`=0), if `tx_en_n` is high at an edge, the next output is the fill character. That is `enc_byte`=0xBC, `enc_k`=1, `enc_viol`=0 and `par_err`=0, whatever the other inputs hold.
- R3: In encoded mode with `tx_en_n` low, if `viol_req` is high the next output is a violation symbol: `enc_viol`=1, `enc_byte`=0x00 and `enc_k`=0, whatever the data and select bits hold.
- R4: In encoded mode with `tx_en_n` low, `viol_req` low and no parity error, `enc_byte` carries `host_word[7:0]`, `enc_k` equals `kd_sel`, and `enc_viol`=0.
- R5: With `par_en` high in encoded mode, the parity group is `viol_req`, `host_word[7:0]`, `kd_sel` and `par_in`, eleven bits in all. The group must hold an odd number of ones. If it holds an even number, `par_err` is high for that one output cycle and a violation symbol (as in R3) goes out in place of the character.
- R6: With `par_en` low, `par_in` has no effect on any output, and `par_err` stays low.
- R7: Priority, highest first: fill (`tx_en_n` high), then parity-error substitution, then violation request, then the normal character. A parity error on a cycle where the enable is deasserted raises no `par_err`.
- R8: In bypass mode (`bypass`=1) with `tx_en_n` low, `raw_word` equals `host_word[9:0]` and `raw_mode`=1. `kd_sel`, `viol_req`, `par_en` and `par_in` have no effect. `enc_byte`, `enc_k`, `enc_viol` and `par_err` are all 0.
- R9: In bypass mode with `tx_en_n` high, `raw_word` is the running-disparity-negative K28.5 code 10'b0011111010 (0x0FA) and `raw_mode`=1. In encoded mode `raw_word` is 0 and `raw_mode` is 0.
- R10: A synchronous active-high reset gives the following outputs: `enc_byte`=0xBC, `enc_k`=1, `enc_viol`=0, `par_err`=0, `raw_word`=0 and `raw_mode`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all capture on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tx_en_n | input | 1 | Transmit enable, active low |
| bypass | input | 1 | 1 selects pre-encoded pass-through |
| host_word | input | 10 | Host character; bits 7:0 are data in encoded mode, all 10 bits are raw in bypass |
| viol_req | input | 1 | Request to send a violation symbol |
| kd_sel | input | 1 | 1 = special character code, 0 = data character |
| par_en | input | 1 | Enable odd-parity checking |
| par_in | input | 1 | Parity bit supplied by the host |
| enc_byte | output | 8 | Byte presented to the encoder |
| enc_k | output | 1 | Special-character flag for the encoder |
| enc_viol | output | 1 | Strobe: encoder emits a violation symbol |
| raw_word | output | 10 | Pre-encoded word in bypass mode |
| raw_mode | output | 1 | 1 when `raw_word` is the word to serialize |
| par_err | output | 1 | One-cycle parity-error pulse |

## Verification
The hardest case to reach is a parity error that collides with other conditions in the same cycle. One collision is a bad parity bit together with a violation request. Another is a bad parity bit on a cycle where the enable is deasserted, where fill must win and the error pulse must stay low. A third is a bad parity bit while in bypass, where it must be ignored. The directed stimulus computes the parity bit for each character and then flips it deliberately while the other control bits are set to each of these states. A long run of random vectors then mixes all the control bits, so that back-to-back errors, runs of fill and switches into and out of bypass occur in every combination.

// File: rtl/txfe_pkg.sv
`timescale 1ns/1ps
package txfe_pkg;
    localparam int DATA_W = 8;
    localparam int RAW_W  = DATA_W + 2;
    localparam int GRP_W  = DATA_W + 2;   // viol_req + data + kd_sel

    typedef enum logic [1:0] {
        PICK_FILL = 2'd0,
        PICK_PERR = 2'd1,
        PICK_VIOL = 2'd2,
        PICK_CHAR = 2'd3
    } pick_e;

    typedef struct packed {
        logic [DATA_W-1:0] bval;
        logic              k;
        logic              viol;
        logic [RAW_W-1:0]  raw;
        logic              raw_mode;
        logic              perr;
    } out_s;
endpackage

// File: rtl/txfe_parity.sv
`timescale 1ns/1ps
module txfe_parity #(
    parameter int W = 10
) (
    input  logic [W-1:0] grp,
    input  logic         par_bit,
    input  logic         chk_en,
    output logic         bad
);
    logic ones_odd;

    always_comb begin
        ones_odd = (^grp) ^ par_bit;
        bad      = chk_en & ~ones_odd;
    end
endmodule

// File: rtl/txfe_pick.sv
`timescale 1ns/1ps
module txfe_pick
    import txfe_pkg::*;
(
    input  logic  idle,
    input  logic  raw_path,
    input  logic  perr,
    input  logic  viol_req,
    output pick_e pick
);
    always_comb begin
        if (idle) begin
            pick = PICK_FILL;
        end else if (raw_path) begin
            pick = PICK_CHAR;
        end else if (perr) begin
            pick = PICK_PERR;
        end else if (viol_req) begin
            pick = PICK_VIOL;
        end else begin
            pick = PICK_CHAR;
        end
    end
endmodule

// File: rtl/txfe_front_sel.sv
`timescale 1ns/1ps
module txfe_front_sel
    import txfe_pkg::*;
#(
    parameter logic [DATA_W-1:0] FILL_BYTE = 8'hBC,
    parameter logic [DATA_W-1:0] VIOL_BYTE = 8'h00,
    parameter logic [RAW_W-1:0]  FILL_RAW  = 10'b0011111010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en_n,
    input  logic              bypass,
    input  logic [RAW_W-1:0]  host_word,
    input  logic              viol_req,
    input  logic              kd_sel,
    input  logic              par_en,
    input  logic              par_in,
    output logic [DATA_W-1:0] enc_byte,
    output logic              enc_k,
    output logic              enc_viol,
    output logic [RAW_W-1:0]  raw_word,
    output logic              raw_mode,
    output logic              par_err
);
    localparam out_s RESET_OUT = '{
        bval: FILL_BYTE, k: 1'b1, viol: 1'b0,
        raw: '0, raw_mode: 1'b0, perr: 1'b0
    };

    logic [GRP_W-1:0] par_grp;
    logic             perr_raw;
    pick_e            pick;
    out_s             out_d, out_q;

    assign par_grp = {viol_req, host_word[DATA_W-1:0], kd_sel};

    txfe_parity #(.W(GRP_W)) u_par (
        .grp     (par_grp),
        .par_bit (par_in),
        .chk_en  (par_en & ~bypass),
        .bad     (perr_raw)
    );

    txfe_pick u_pick (
        .idle     (tx_en_n),
        .raw_path (bypass),
        .perr     (perr_raw),
        .viol_req (viol_req),
        .pick     (pick)
    );

    always_comb begin
        out_d = '0;
        unique case (pick)
            PICK_FILL: begin
                if (bypass) begin
                    out_d.raw      = FILL_RAW;
                    out_d.raw_mode = 1'b1;
                end else begin
                    out_d.bval = FILL_BYTE;
                    out_d.k    = 1'b1;
                end
            end
            PICK_PERR: begin
                out_d.bval = VIOL_BYTE;
                out_d.viol = 1'b1;
                out_d.perr = 1'b1;
            end
            PICK_VIOL: begin
                out_d.bval = VIOL_BYTE;
                out_d.viol = 1'b1;
            end
            default: begin
                if (bypass) begin
                    out_d.raw      = host_word;
                    out_d.raw_mode = 1'b1;
                end else begin
                    out_d.bval = host_word[DATA_W-1:0];
                    out_d.k    = kd_sel;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= RESET_OUT;
        end else begin
            out_q <= out_d;
        end
    end

    assign enc_byte = out_q.bval;
    assign enc_k    = out_q.k;
    assign enc_viol = out_q.viol;
    assign raw_word = out_q.raw;
    assign raw_mode = out_q.raw_mode;
    assign par_err  = out_q.perr;
endmodule

// File: rtl/txfe_checker.sv
`timescale 1ns/1ps
module txfe_checker
    import txfe_pkg::*;
#(
    parameter logic [DATA_W-1:0] FILL_BYTE = 8'hBC,
    parameter logic [DATA_W-1:0] VIOL_BYTE = 8'h00
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_en_n,
    input logic              bypass,
    input logic [RAW_W-1:0]  host_word,
    input logic              viol_req,
    input logic              kd_sel,
    input logic              par_en,
    input logic              par_in,
    input logic [DATA_W-1:0] enc_byte,
    input logic              enc_k,
    input logic              enc_viol,
    input logic [RAW_W-1:0]  raw_word,
    input logic              raw_mode,
    input logic              par_err
);
    // live_q: the previous edge was not a reset edge, so the outputs reflect the inputs
    logic live_q;
    always_ff @(posedge clk) live_q <= !rst;

    assert_fill_R2: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(tx_en_n) && !$past(bypass))
        |-> (enc_k && enc_byte == FILL_BYTE && !enc_viol && !par_err));

    assert_viol_req_R3: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(tx_en_n) && !$past(bypass) && $past(viol_req))
        |-> (enc_viol && !enc_k && enc_byte == VIOL_BYTE));

    assert_char_pass_R4: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(tx_en_n) && !$past(bypass) && !$past(viol_req) && !$past(par_en))
        |-> (enc_byte == $past(host_word[DATA_W-1:0]) && enc_k == $past(kd_sel) && !enc_viol));

    assert_perr_subst_R5: assert property (@(posedge clk) disable iff (rst)
        par_err |-> (enc_viol && !enc_k && !raw_mode));

    assert_perr_off_R6: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(par_en)) |-> !par_err);

    assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(bypass) && !$past(tx_en_n))
        |-> (raw_mode && raw_word == $past(host_word) && !enc_viol && !par_err && !enc_k));

    assert_kind_excl_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({enc_k, enc_viol, raw_mode}));
endmodule

bind txfe_front_sel txfe_checker #(
    .FILL_BYTE (FILL_BYTE),
    .VIOL_BYTE (VIOL_BYTE)
) u_chk (.*);

// File: tb/tb_txfe_front_sel.sv
`timescale 1ns/1ps
module tb_txfe_front_sel;
    logic       clk = 1'b0;
    logic       rst;
    logic       tx_en_n, bypass, viol_req, kd_sel, par_en, par_in;
    logic [9:0] host_word;
    logic [7:0] enc_byte;
    logic       enc_k, enc_viol, raw_mode, par_err;
    logic [9:0] raw_word;

    always #5 clk = ~clk;

    txfe_front_sel dut (
        .clk(clk), .rst(rst), .tx_en_n(tx_en_n), .bypass(bypass),
        .host_word(host_word), .viol_req(viol_req), .kd_sel(kd_sel),
        .par_en(par_en), .par_in(par_in), .enc_byte(enc_byte), .enc_k(enc_k),
        .enc_viol(enc_viol), .raw_word(raw_word), .raw_mode(raw_mode),
        .par_err(par_err)
    );

    // expected layout: {byte[7:0], k, viol, raw[9:0], raw_mode, perr} = 22 bits
    logic [21:0] exp_q[$];
    int          due_q[$];
    string       tag_q[$];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [21:0] model(input logic en_n, input logic byp,
            input logic [9:0] w, input logic vr, input logic sel,
            input logic pe, input logic pi);
        logic odd_ok;
        odd_ok = ^{vr, w[7:0], sel, pi};
        if (en_n)              return byp ? {8'h00, 2'b00, 10'h0FA, 1'b1, 1'b0}   // R9 fill raw
                                          : {8'hBC, 2'b10, 10'h000, 2'b00};      // R2 fill
        if (byp)               return {8'h00, 2'b00, w, 1'b1, 1'b0};             // R8
        if (pe && !odd_ok)     return {8'h00, 2'b01, 10'h000, 1'b0, 1'b1};       // R5
        if (vr)                return {8'h00, 2'b01, 10'h000, 2'b00};            // R3
        return {w[7:0], sel, 1'b0, 10'h000, 2'b00};                               // R4
    endfunction

    function automatic logic [21:0] seen();
        return {enc_byte, enc_k, enc_viol, raw_word, raw_mode, par_err};
    endfunction

    // driver: applies one vector just after an edge; the result is due after the next edge
    task automatic drive(input string tag, input logic en_n, input logic byp,
            input logic [9:0] w, input logic vr, input logic sel,
            input logic pe, input logic pi);
        @(posedge clk);
        #1;
        tx_en_n = en_n; bypass = byp; host_word = w; viol_req = vr;
        kd_sel = sel; par_en = pe; par_in = pi;
        exp_q.push_back(model(en_n, byp, w, vr, sel, pe, pi));
        due_q.push_back(cyc + 1);
        tag_q.push_back(tag);
    endtask

    // monitor: compares at the falling edge after the capturing edge
    always @(negedge clk) begin
        while (exp_q.size() > 0 && due_q[0] == cyc) begin
            logic [21:0] e;
            string t;
            e = exp_q.pop_front();
            void'(due_q.pop_front());
            t = tag_q.pop_front();
            n_chk++;
            if (seen() !== e) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", t, seen(), e);
            end
        end
    end

    function automatic logic good_par(input logic vr, input logic [7:0] d, input logic sel);
        return ~^{vr, d, sel};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tx_en_n = 1'b0; bypass = 1'b0; host_word = 10'h3A5;
        viol_req = 1'b0; kd_sel = 1'b0; par_en = 1'b0; par_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        n_chk++;
        if (seen() !== {8'hBC, 2'b10, 10'h000, 2'b00}) begin
            n_bad++;
            $display("FAIL R10: got %h expected %h", seen(), {8'hBC, 2'b10, 10'h000, 2'b00});
        end
        @(posedge clk); #1 rst = 1'b0;

        // R4 / R1 plain data and special characters, back to back
        drive("R4", 0, 0, 10'h055, 0, 0, 0, 0);
        drive("R1", 0, 0, 10'h0AA, 0, 0, 0, 1);
        drive("R4", 0, 0, 10'h0BC, 0, 1, 0, 0);
        drive("R4", 0, 0, 10'h3FF, 0, 0, 0, 0);
        // R2 fill, with junk on other inputs
        drive("R2", 1, 0, 10'h123, 1, 1, 1, 0);
        drive("R2", 1, 0, 10'h000, 0, 0, 0, 0);
        // R3 violation request over data and special select
        drive("R3", 0, 0, 10'h0F0, 1, 0, 0, 0);
        drive("R3", 0, 0, 10'h01C, 1, 1, 0, 1);
        // R5 parity good and bad
        drive("R5", 0, 0, 10'h037, 0, 0, 1, good_par(0, 8'h37, 0));
        drive("R5", 0, 0, 10'h037, 0, 0, 1, ~good_par(0, 8'h37, 0));
        drive("R5", 0, 0, 10'h0E1, 0, 1, 1, ~good_par(0, 8'hE1, 1));
        drive("R5", 0, 0, 10'h0E1, 0, 1, 1, good_par(0, 8'hE1, 1));
        // R6 parity disabled: both values of par_in give the same character
        drive("R6", 0, 0, 10'h066, 0, 0, 0, 0);
        drive("R6", 0, 0, 10'h066, 0, 0, 0, 1);
        // R7 collisions: bad parity under fill, bad parity with violation request
        drive("R7", 1, 0, 10'h011, 0, 0, 1, ~good_par(0, 8'h11, 0));
        drive("R7", 0, 0, 10'h011, 1, 0, 1, ~good_par(1, 8'h11, 0));
        drive("R7", 0, 0, 10'h011, 1, 0, 1, good_par(1, 8'h11, 0));
        // R8 bypass pass-through, control bits ignored, bad parity ignored
        drive("R8", 0, 1, 10'h2C7, 1, 1, 1, 0);
        drive("R8", 0, 1, 10'h17C, 0, 0, 1, 1);
        drive("R8", 0, 1, 10'h3FF, 1, 0, 0, 0);
        // R9 bypass fill, then back to encoded mode
        drive("R9", 1, 1, 10'h155, 1, 1, 1, 0);
        drive("R9", 0, 0, 10'h042, 0, 0, 0, 0);

        // mixed random run
        for (int i = 0; i < 300; i++) begin
            logic [9:0] w;
            logic en_n, byp, vr, sel, pe, pi;
            w    = 10'($urandom);
            en_n = ($urandom % 4) == 0;
            byp  = ($urandom % 5) == 0;
            vr   = ($urandom % 6) == 0;
            sel  = 1'($urandom);
            pe   = 1'($urandom);
            pi   = (($urandom % 3) == 0) ? ~good_par(vr, w[7:0], sel) : good_par(vr, w[7:0], sel);
            drive("R7 mix", en_n, byp, w, vr, sel, pe, pi);
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R1: got %0d pending expected 0", exp_q.size());
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule